// File: doc/BRIEF.md
# SDRAM Read Sequencing Checker

This block watches the command bus of an SDRAM device and keeps, for each of its banks, whether the bank is open and which row it holds. Every READ is checked against that state. A READ to a closed bank, or to a row other than the open one, is reported as a one-cycle violation pulse with a reason code. An illegal READ is otherwise ignored.

In parallel, the block predicts the read data timeline. For every legal READ it produces a stream of tags (start column plus beat index) that names the data word the device drives on each clock. A tag appears a fixed latency after the command, and a burst runs for a fixed number of words. A later READ, to the same bank or to another open bank, cuts the running burst short: from its own latency onward only the newer burst's words are tagged. A scoreboard next to the real data bus can use the tags to check or label returned data.

The tag output is a valid-only stream with no ready input. The observed bus cannot be stalled, so back-pressure is not possible. A tag is present for exactly the one clock in which `tag_valid_o` is high and must be taken in that clock.

Top module: `rdseq_monitor`

## Requirements
- R1: After reset every bank is closed, `tag_valid_o` and `viol_o` are low, and the first READ after reset is reported as bank-not-active.
- R2: `cmd_i` encodes NOP=0, ACTIVATE=1, READ=2, PRECHARGE=3. ACTIVATE opens bank `bank_i` with row `row_i`. PRECHARGE closes bank `bank_i`. A READ names its intended row on `row_i` and its start column on `col_i`.
- R3: A READ to a closed bank raises `viol_o` with `viol_code_o`=1 for the single clock after the command edge, and it produces no tags.
- R4: A READ to an open bank whose `row_i` differs from the open row raises `viol_o` with `viol_code_o`=2 for one clock, and it produces no tags.
- R5: A legal READ sampled at edge k gives tags with column `col_i` and beats 0,1,2,3 after edges k+4 to k+7. `tag_valid_o` falls after edge k+8 if no later READ is legal.
- R6: A legal READ to the same bank and row one or more clocks after another READ truncates the earlier burst. From the newer read's own latency onward, only its tags appear, starting at beat 0.
- R7: A READ to a different open bank may follow one clock after a READ. It is legal and truncates the earlier burst in the same way.
- R8: An illegal READ leaves any burst in flight untouched. The burst runs to its last beat.
- R9: After PRECHARGE a READ to that bank is bank-not-active. After a new ACTIVATE, READs to the new row are legal and READs to the old row are row mismatch.
- R10: Back-to-back legal READs on every clock keep `tag_valid_o` high continuously, with each tag at beat 0 of its own read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Observed command (NOP/ACTIVATE/READ/PRECHARGE) |
| bank_i | input | 2 | Observed bank address |
| row_i | input | 13 | Row for ACTIVATE, intended row for READ |
| col_i | input | 10 | Start column for READ |
| tag_valid_o | output | 1 | A data word is on the bus this clock |
| tag_col_o | output | 10 | Start column of the burst owning the word |
| tag_beat_o | output | 2 | Position of the word within its burst |
| viol_o | output | 1 | One-clock pulse for an illegal READ |
| viol_code_o | output | 2 | 1 = bank not active, 2 = row mismatch, 0 otherwise |

## Verification
If a bank's open flag or stored row is wrong, the next READ to that bank gives the wrong violation verdict one clock after its edge. Four clocks later a burst appears that should not exist, or an expected burst is missing. A wrong latency stage or beat counter shows up as a tag that is early, late, repeated or cut short, at the first clock of the affected burst. The bench compares every output against a queue-based behavioural model on every clock, so such a fault is reported in the cycle it first becomes visible.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_READ = 3'd2,
    CMD_PRE  = 3'd3
  } cmd_e;

  typedef enum logic [1:0] {
    VIOL_NONE = 2'd0,
    VIOL_IDLE = 2'd1,
    VIOL_ROW  = 2'd2
  } viol_e;
endpackage

// File: rtl/rdseq_bank_track.sv
module rdseq_bank_track
  import rdseq_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int BA_W  = 2,
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_i,
  input  logic [BA_W-1:0]  bank_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             rd_ok_o,
  output logic             viol_o,
  output logic [1:0]       viol_code_o
);
  logic [BANKS-1:0] open_q;
  logic [ROW_W-1:0] open_row_q [BANKS];
  logic             sel_open;
  logic [ROW_W-1:0] sel_row;
  logic             is_read;

  genvar b;
  generate
    for (b = 0; b < BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          open_q[b]     <= 1'b0;
          open_row_q[b] <= '0;
        end else if (bank_i == BA_W'(b)) begin
          if (cmd_i == CMD_ACT) begin
            open_q[b]     <= 1'b1;
            open_row_q[b] <= row_i;
          end else if (cmd_i == CMD_PRE) begin
            open_q[b] <= 1'b0;
          end
        end
      end

      // R9
      pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PRE && bank_i == BA_W'(b)) |=> !open_q[b]);
    end
  endgenerate

  always_comb begin
    sel_open = open_q[bank_i];
    sel_row  = open_row_q[bank_i];
    is_read  = (cmd_i == CMD_READ);
    rd_ok_o  = is_read && sel_open && (sel_row == row_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_o      <= 1'b0;
      viol_code_o <= VIOL_NONE;
    end else begin
      viol_o      <= is_read && !rd_ok_o;
      viol_code_o <= (is_read && !rd_ok_o) ? (sel_open ? VIOL_ROW : VIOL_IDLE) : VIOL_NONE;
    end
  end

  // R3
  viol_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> ($past(cmd_i) == CMD_READ));
  // R4
  code_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o == (viol_code_o != VIOL_NONE));
endmodule

// File: rtl/rdseq_lat_pipe.sv
module rdseq_lat_pipe #(
  parameter int LAT   = 4,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [COL_W-1:0] in_col,
  output logic             out_v,
  output logic [COL_W-1:0] out_col
);
  logic             v_q   [LAT];
  logic [COL_W-1:0] col_q [LAT];

  genvar i;
  generate
    for (i = 0; i < LAT; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            v_q[0]   <= 1'b0;
            col_q[0] <= '0;
          end else begin
            v_q[0]   <= in_v;
            col_q[0] <= in_col;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            v_q[i]   <= 1'b0;
            col_q[i] <= '0;
          end else begin
            v_q[i]   <= v_q[i-1];
            col_q[i] <= col_q[i-1];
          end
        end

        // R5
        stage_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
          v_q[i] |-> $past(v_q[i-1]));
      end
    end
  endgenerate

  assign out_v   = v_q[LAT-1];
  assign out_col = col_q[LAT-1];
endmodule

// File: rtl/rdseq_burst_gen.sv
module rdseq_burst_gen #(
  parameter int BL     = 4,
  parameter int BEAT_W = 2,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_v,
  input  logic [COL_W-1:0]  ld_col,
  output logic              valid_o,
  output logic [COL_W-1:0]  col_o,
  output logic [BEAT_W-1:0] beat_o
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BL - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      col_o   <= '0;
      beat_o  <= '0;
    end else if (ld_v) begin
      valid_o <= 1'b1;
      col_o   <= ld_col;
      beat_o  <= '0;
    end else if (valid_o) begin
      if (beat_o == LAST) begin
        valid_o <= 1'b0;
        beat_o  <= '0;
      end else begin
        beat_o <= beat_o + BEAT_W'(1);
      end
    end
  end

  // R5
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && beat_o != '0) |-> ($past(valid_o) && $past(beat_o) == beat_o - BEAT_W'(1)));
  // R5
  col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && beat_o != '0) |-> $stable(col_o));
  // R6
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && beat_o == LAST && !ld_v) |=> !valid_o);
endmodule

// File: rtl/rdseq_monitor.sv
module rdseq_monitor
  import rdseq_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int LAT   = 4,
  parameter int BL    = 4,
  parameter int BA_W  = (BANKS > 1) ? $clog2(BANKS) : 1,
  parameter int BEAT_W = (BL > 1) ? $clog2(BL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic [BA_W-1:0]   bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  output logic              tag_valid_o,
  output logic [COL_W-1:0]  tag_col_o,
  output logic [BEAT_W-1:0] tag_beat_o,
  output logic              viol_o,
  output logic [1:0]        viol_code_o
);
  logic             rd_ok;
  logic             pipe_v;
  logic [COL_W-1:0] pipe_col;

  rdseq_bank_track #(.BANKS(BANKS), .BA_W(BA_W), .ROW_W(ROW_W)) u_track (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .row_i(row_i),
    .rd_ok_o(rd_ok), .viol_o(viol_o), .viol_code_o(viol_code_o)
  );

  rdseq_lat_pipe #(.LAT(LAT), .COL_W(COL_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_v(rd_ok), .in_col(col_i),
    .out_v(pipe_v), .out_col(pipe_col)
  );

  rdseq_burst_gen #(.BL(BL), .BEAT_W(BEAT_W), .COL_W(COL_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .ld_v(pipe_v), .ld_col(pipe_col),
    .valid_o(tag_valid_o), .col_o(tag_col_o), .beat_o(tag_beat_o)
  );

  // R8
  no_viol_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> !rd_ok || $past(cmd_i) == CMD_READ);
  // R10
  reload_beat0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_v |=> (tag_valid_o && tag_beat_o == '0));
endmodule

// File: tb/rdseq_monitor_bench.sv
module rdseq_monitor_bench;
  localparam int LAT = 4;
  localparam int BL  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd_i = 3'd0;
  logic [1:0]  bank_i = 2'd0;
  logic [12:0] row_i = '0;
  logic [9:0]  col_i = '0;
  logic        tag_valid_o;
  logic [9:0]  tag_col_o;
  logic [1:0]  tag_beat_o;
  logic        viol_o;
  logic [1:0]  viol_code_o;

  rdseq_monitor u_rdseq_monitor (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .row_i(row_i),
    .col_i(col_i), .tag_valid_o(tag_valid_o), .tag_col_o(tag_col_o),
    .tag_beat_o(tag_beat_o), .viol_o(viol_o), .viol_code_o(viol_code_o)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int edge_n = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_open [4];
  int m_row  [4];
  int rd_cyc [$];
  int rd_col [$];
  int e_viol = 0;
  int e_code = 0;

  task automatic model_update(int c, int b, int r, int col);
    e_viol = 0;
    e_code = 0;
    if (c == 2) begin
      if (m_open[b] == 0) begin e_viol = 1; e_code = 1; end
      else if (m_row[b] != r) begin e_viol = 1; e_code = 2; end
      else begin rd_cyc.push_back(edge_n); rd_col.push_back(col); end
    end else if (c == 1) begin
      m_open[b] = 1; m_row[b] = r;
    end else if (c == 3) begin
      m_open[b] = 0;
    end
  endtask

  task automatic check_all();
    int ev = 0; int ec = 0; int eb = 0;
    for (int i = rd_cyc.size() - 1; i >= 0; i--) begin
      if (rd_cyc[i] <= edge_n - LAT) begin
        if (edge_n - rd_cyc[i] < LAT + BL) begin
          ev = 1; ec = rd_col[i]; eb = edge_n - rd_cyc[i] - LAT;
        end
        break;
      end
    end
    total++;
    if (int'(viol_o) != e_viol || int'(viol_code_o) != e_code) begin
      bad++;
      $display("FAIL %s viol edge %0d: got %0d/%0d exp %0d/%0d",
               cur_req, edge_n, viol_o, viol_code_o, e_viol, e_code);
    end
    total++;
    if (int'(tag_valid_o) != ev ||
        (ev == 1 && (int'(tag_col_o) != ec || int'(tag_beat_o) != eb))) begin
      bad++;
      $display("FAIL %s tag edge %0d: got v=%0d col=%0d beat=%0d exp v=%0d col=%0d beat=%0d",
               cur_req, edge_n, tag_valid_o, tag_col_o, tag_beat_o, ev, ec, eb);
    end
  endtask

  task automatic step(int c, int b, int r, int col);
    cmd_i = 3'(c); bank_i = 2'(b); row_i = 13'(r); col_i = 10'(col);
    @(posedge clk);
    edge_n++;
    model_update(c, b, r, col);
    @(negedge clk);
    check_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    total++;
    if (tag_valid_o !== 1'b0 || viol_o !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: got v=%0d viol=%0d exp 0/0", tag_valid_o, viol_o);
    end
    rst_n = 1'b1;
    cur_req = "R1"; idle(2);
    step(2, 1, 0, 3);            // R1, R3: first read after reset, bank closed
    idle(6);
    cur_req = "R2";  step(1, 0, 5, 0); // R2: ACTIVATE opens row 5
    cur_req = "R5";  step(2, 0, 5, 16); idle(9);  // R5: plain burst
    cur_req = "R6";  step(2, 0, 5, 32); step(2, 0, 5, 48); idle(5);
    step(2, 0, 5, 200); idle(2); step(2, 0, 5, 220); idle(9); // R6: gap of 3
    cur_req = "R7";  step(1, 3, 7, 0); step(2, 0, 5, 64); step(2, 3, 7, 80); idle(9);
    cur_req = "R8";  step(2, 0, 5, 96); step(2, 0, 9, 100); // R4 row mismatch
    cur_req = "R3";  step(2, 2, 5, 104);                    // R3 bank closed
    cur_req = "R8";  idle(8);
    cur_req = "R9";  step(3, 0, 0, 0); step(2, 0, 5, 1);
    step(1, 0, 9, 0); step(2, 0, 9, 112); step(2, 0, 5, 113); idle(9);
    cur_req = "R4";  step(2, 3, 8, 5); idle(2);
    cur_req = "R10";
    for (int i = 1; i <= 6; i++) step(2, (i % 2 == 0) ? 3 : 0, (i % 2 == 0) ? 7 : 9, i);
    idle(10);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hang exp finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule